// File: doc/BRIEF.md
# Arithmetic Status Flag Unit

This block sits beside the adder of a 16-bit integer datapath. It forms the sum or the difference of two operands with a carry or borrow input. The width select decides whether the operation runs on the full 16-bit word or on the low byte only. From the carry chain and the result it derives six condition flags: carry, parity, auxiliary carry, zero, sign and overflow.

The condition flags are loaded into a 16-bit flag register on a clock edge only when the update strobe is high. The register also holds three control flags: direction, interrupt enable and trap. These change only through per-flag set and clear inputs and are never touched by arithmetic.

The datapath reads the combinational result and the registered flag word. Unused flag bits read as fixed constants.

Top module: `arith_flag_unit`

## Requirements
- R1: `result` is `op_a + op_b + carry_in` when `op_sub`=0, and `op_a - op_b - carry_in` when `op_sub`=1, taken modulo the active width. When `wide`=0 only the low 8 operand bits are used and `result[15:8]` is 0.
- R2: The carry flag is the carry out of bit 7 (narrow) or bit 15 (wide) for an add. For a subtract it is the borrow, which is 1 when the unsigned minuend is less than the subtrahend plus `carry_in`.
- R3: The auxiliary flag is the carry from bit 3 into bit 4 for an add. For a subtract it is the borrow out of the low nibble.
- R4: The overflow flag is 1 when exactly one of these two carries is set: the carry into the sign bit (bit 7 or bit 15) and the carry out of it. This matches a signed result outside the range of the active width.
- R5: The zero flag is 1 when the active-width result is zero. The sign flag copies bit 7 (narrow) or bit 15 (wide) of the result.
- R6: The parity flag is 1 when `result[7:0]` holds an even number of ones, whatever the width.
- R7: On a rising edge with `arith_en`=1, the six condition flags take the values computed from the inputs. With `arith_en`=0 they hold. Arithmetic never changes a control flag.
- R8: Control flag index k (0 trap, 1 interrupt enable, 2 direction) is set by `ctl_set[k]` and cleared by `ctl_clr[k]` on a rising edge. Clear wins when both are high. Without either, the flag holds.
- R9: While `rst_n` is low, all nine flags are 0 and `flags` reads 16'h0002.
- R10: The layout of `flags` is carry 0, parity 2, auxiliary 4, zero 6, sign 7, trap 8, interrupt enable 9, direction 10, overflow 11. Bit 1 always reads 1, and bits 3, 5 and 12 to 15 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 16 | First operand (minuend for subtract) |
| op_b | input | 16 | Second operand (subtrahend for subtract) |
| carry_in | input | 1 | Carry in for add, borrow in for subtract |
| op_sub | input | 1 | 0 add, 1 subtract |
| wide | input | 1 | 1 for 16-bit operation, 0 for 8-bit |
| arith_en | input | 1 | Load the condition flags at the next edge |
| ctl_set | input | 3 | Set strobes for trap, interrupt enable, direction |
| ctl_clr | input | 3 | Clear strobes for trap, interrupt enable, direction |
| result | output | 16 | Combinational sum or difference |
| flags | output | 16 | Registered packed flag word |

## Verification
The assertions check several properties on every cycle:
- the fixed bits of the flag word and the zeroed upper byte in narrow mode;
- the hold behaviour of both flag groups;
- the precedence of clear over set;
- that the loaded zero, sign and parity flags match the result seen one cycle earlier.

Carry, auxiliary carry and overflow depend on the carry chain. Only the bench can show them correct, by comparing against plain integer arithmetic over a full sweep of one narrow operand, a spread of the other, and a long pseudo-random run in wide mode. The bench scenarios also show that arithmetic leaves the control flags alone and that reset clears the register.

// File: rtl/arith_flag_pkg.sv
package arith_flag_pkg;
   localparam int FLAG_W   = 16;
   localparam int POS_CF   = 0;
   localparam int POS_PF   = 2;
   localparam int POS_AF   = 4;
   localparam int POS_ZF   = 6;
   localparam int POS_SF   = 7;
   localparam int POS_TF   = 8;
   localparam int POS_IF   = 9;
   localparam int POS_DF   = 10;
   localparam int POS_OF   = 11;
   localparam int N_CTL    = 3;
   localparam logic [FLAG_W-1:0] FIXED_VAL = 16'h0002;
   localparam logic [FLAG_W-1:0] LIVE_MASK = 16'h0FD5;

   typedef struct packed {
      logic of;
      logic sf;
      logic zf;
      logic af;
      logic pf;
      logic cf;
   } cond_flags_t;
endpackage

// File: rtl/flag_adder.sv
module flag_adder #(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic [W:0]   carry
);
   logic [W-1:0] b_x;

   assign b_x      = sub ? ~b : b;
   assign carry[0] = cin ^ sub;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign sum[i]     = a[i] ^ b_x[i] ^ carry[i];
      assign carry[i+1] = (a[i] & b_x[i]) | (carry[i] & (a[i] ^ b_x[i]));
   end
endmodule

// File: rtl/flag_eval.sv
module flag_eval
   import arith_flag_pkg::*;
#(
   parameter int WIDE_W   = 16,
   parameter int NARROW_W = 8,
   parameter int NIB_W    = 4
) (
   input  logic [WIDE_W-1:0] sum,
   input  logic [WIDE_W:0]   carry,
   input  logic              wide,
   input  logic              sub,
   output logic [WIDE_W-1:0] result,
   output cond_flags_t       cond
);
   localparam int UPPER_W = WIDE_W - NARROW_W;

   logic c_in_msb;
   logic c_out_msb;

   always_comb begin
      if (wide) begin
         result    = sum;
         c_in_msb  = carry[WIDE_W-1];
         c_out_msb = carry[WIDE_W];
         cond.sf   = sum[WIDE_W-1];
         cond.zf   = (sum == '0);
      end else begin
         result    = {{UPPER_W{1'b0}}, sum[NARROW_W-1:0]};
         c_in_msb  = carry[NARROW_W-1];
         c_out_msb = carry[NARROW_W];
         cond.sf   = sum[NARROW_W-1];
         cond.zf   = (sum[NARROW_W-1:0] == '0);
      end
      cond.cf = c_out_msb ^ sub;
      cond.af = carry[NIB_W] ^ sub;
      cond.of = c_in_msb ^ c_out_msb;
      cond.pf = ~(^sum[NARROW_W-1:0]);
   end
endmodule

// File: rtl/ctl_flag_bank.sv
module ctl_flag_bank #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q
);
   for (genvar k = 0; k < N; k++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q[k] <= 1'b0;
         else if (clr_i[k]) q[k] <= 1'b0;
         else if (set_i[k]) q[k] <= 1'b1;
      end
   end
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
   import arith_flag_pkg::*;
#(
   parameter int WIDE_W   = 16,
   parameter int NARROW_W = 8,
   parameter int NIB_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIDE_W-1:0] op_a,
   input  logic [WIDE_W-1:0] op_b,
   input  logic              carry_in,
   input  logic              op_sub,
   input  logic              wide,
   input  logic              arith_en,
   input  logic [N_CTL-1:0]  ctl_set,
   input  logic [N_CTL-1:0]  ctl_clr,
   output logic [WIDE_W-1:0] result,
   output logic [FLAG_W-1:0] flags
);
   if (WIDE_W != FLAG_W) begin : g_bad_wide
      $error("WIDE_W must equal the flag word width");
   end
   if (NARROW_W >= WIDE_W || NARROW_W < 8) begin : g_bad_narrow
      $error("NARROW_W must be at least 8 and below WIDE_W");
   end
   if (NIB_W < 1 || NIB_W >= NARROW_W) begin : g_bad_nib
      $error("NIB_W must lie inside the narrow width");
   end

   logic [WIDE_W-1:0] sum;
   logic [WIDE_W:0]   carry;
   cond_flags_t       cond_next;
   cond_flags_t       cond_q;
   logic [N_CTL-1:0]  ctl_q;

   flag_adder #(.W(WIDE_W)) u_add (
      .a     (op_a),
      .b     (op_b),
      .cin   (carry_in),
      .sub   (op_sub),
      .sum   (sum),
      .carry (carry)
   );

   flag_eval #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .NIB_W(NIB_W)) u_eval (
      .sum    (sum),
      .carry  (carry),
      .wide   (wide),
      .sub    (op_sub),
      .result (result),
      .cond   (cond_next)
   );

   ctl_flag_bank #(.N(N_CTL)) u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ctl_set),
      .clr_i (ctl_clr),
      .q     (ctl_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cond_q <= '0;
      else if (arith_en) cond_q <= cond_next;
   end

   always_comb begin
      flags         = FIXED_VAL;
      flags[POS_CF] = cond_q.cf;
      flags[POS_PF] = cond_q.pf;
      flags[POS_AF] = cond_q.af;
      flags[POS_ZF] = cond_q.zf;
      flags[POS_SF] = cond_q.sf;
      flags[POS_OF] = cond_q.of;
      flags[POS_TF] = ctl_q[0];
      flags[POS_IF] = ctl_q[1];
      flags[POS_DF] = ctl_q[2];
   end
endmodule

// File: rtl/arith_flag_unit_chk.sv
module arith_flag_unit_chk
   import arith_flag_pkg::*;
#(
   parameter int WIDE_W   = 16,
   parameter int NARROW_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wide,
   input logic              arith_en,
   input logic [N_CTL-1:0]  ctl_set,
   input logic [N_CTL-1:0]  ctl_clr,
   input logic [WIDE_W-1:0] result,
   input logic [FLAG_W-1:0] flags
);
   localparam logic [FLAG_W-1:0] COND_MASK = 16'h08D5;

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_clear_R9: assert (flags == FIXED_VAL);
      end
   end

   assert_fixed_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flags & ~LIVE_MASK) == FIXED_VAL);

   assert_narrow_upper_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !wide |-> result[WIDE_W-1:NARROW_W] == '0);

   assert_cond_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !arith_en |=> (flags & COND_MASK) == $past(flags & COND_MASK));

   assert_zero_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      arith_en |=> flags[POS_ZF] == ($past(result) == '0));

   assert_sign_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      arith_en |=> flags[POS_SF] ==
         $past(wide ? result[WIDE_W-1] : result[NARROW_W-1]));

   assert_parity_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      arith_en |=> flags[POS_PF] == ~(^$past(result[7:0])));

   assert_ctl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_set == '0 && ctl_clr == '0) |=> $stable(flags[POS_DF:POS_TF]));

   for (genvar k = 0; k < N_CTL; k++) begin : g_ctl
      assert_ctl_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
         ctl_clr[k] |=> !flags[POS_TF+k]);
      assert_ctl_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (ctl_set[k] && !ctl_clr[k]) |=> flags[POS_TF+k]);
   end
endmodule

bind arith_flag_unit arith_flag_unit_chk #(
   .WIDE_W   (WIDE_W),
   .NARROW_W (NARROW_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wide     (wide),
   .arith_en (arith_en),
   .ctl_set  (ctl_set),
   .ctl_clr  (ctl_clr),
   .result   (result),
   .flags    (flags)
);

// File: tb/arith_flag_unit_bench.sv
module arith_flag_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] op_a = '0;
   logic [15:0] op_b = '0;
   logic        carry_in = 1'b0;
   logic        op_sub = 1'b0;
   logic        wide = 1'b0;
   logic        arith_en = 1'b0;
   logic [2:0]  ctl_set = '0;
   logic [2:0]  ctl_clr = '0;
   logic [15:0] result;
   logic [15:0] flags;

   int n_cmp = 0;
   int n_bad = 0;
   logic done = 1'b0;

   always #4 clk = ~clk;

   arith_flag_unit u_arith_flag_unit (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
      .op_sub(op_sub), .wide(wide), .arith_en(arith_en), .ctl_set(ctl_set),
      .ctl_clr(ctl_clr), .result(result), .flags(flags)
   );

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   logic [15:0] e_res;
   logic        e_cf, e_af, e_of, e_zf, e_sf, e_pf;

   task automatic model(input logic [15:0] a, input logic [15:0] b,
                        input logic ci, input logic sb, input logic wd);
      int w = wd ? 16 : 8;
      int m = (1 << w) - 1;
      int ua = int'(a) & m;
      int ub = int'(b) & m;
      int sa = (ua >= (1 << (w-1))) ? ua - (1 << w) : ua;
      int sbv = (ub >= (1 << (w-1))) ? ub - (1 << w) : ub;
      int full, sres;
      if (!sb) begin
         full = ua + ub + int'(ci);
         e_cf = full > m;
         e_af = ((ua & 15) + (ub & 15) + int'(ci)) > 15;
         sres = sa + sbv + int'(ci);
      end else begin
         full = ua - ub - int'(ci);
         e_cf = ua < ub + int'(ci);
         e_af = (ua & 15) < (ub & 15) + int'(ci);
         sres = sa - sbv - int'(ci);
      end
      e_res = 16'(full & m);
      e_of  = (sres > (1 << (w-1)) - 1) || (sres < -(1 << (w-1)));
      e_zf  = (e_res == 16'h0);
      e_sf  = e_res[w-1];
      e_pf  = ~(^e_res[7:0]);
   endtask

   // drive at negedge, compare result, compare flags one negedge later
   task automatic run_vec(input logic [15:0] a, input logic [15:0] b,
                          input logic ci, input logic sb, input logic wd);
      logic [15:0] ctl_keep;
      op_a = a; op_b = b; carry_in = ci; op_sub = sb; wide = wd; arith_en = 1'b1;
      model(a, b, ci, sb, wd);
      ctl_keep = flags & 16'h0700;
      #1;
      check("R1", "result", result, e_res);
      @(negedge clk);
      arith_en = 1'b0;
      check("R2", "carry", {15'h0, flags[0]}, {15'h0, e_cf});
      check("R3", "aux", {15'h0, flags[4]}, {15'h0, e_af});
      check("R4", "overflow", {15'h0, flags[11]}, {15'h0, e_of});
      check("R5", "zero/sign", {14'h0, flags[6], flags[7]}, {14'h0, e_zf, e_sf});
      check("R6", "parity", {15'h0, flags[2]}, {15'h0, e_pf});
      check("R7", "ctl untouched", flags & 16'h0700, ctl_keep);
      check("R10", "fixed bits", flags & 16'hF02A, 16'h0002);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] lf;
      logic [15:0] held;
      repeat (2) @(negedge clk);
      check("R9", "reset word", flags, 16'h0002);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9", "after reset", flags, 16'h0002);

      // narrow: full sweep of op_a, 16 op_b values, all carry/op combinations
      for (int ia = 0; ia < 256; ia++)
         for (int ib = 0; ib < 16; ib++)
            for (int k = 0; k < 4; k++)
               run_vec(16'(ia) | 16'hA500, 16'((ib * 17) ^ (ib << 3)) | 16'h5A00,
                       k[0], k[1], 1'b0);

      // narrow corners
      run_vec(16'h007F, 16'h0001, 1'b0, 1'b0, 1'b0); // R4 positive overflow
      run_vec(16'h0080, 16'h0001, 1'b0, 1'b1, 1'b0); // R4 negative overflow
      run_vec(16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0); // R2 borrow from zero
      run_vec(16'h00FF, 16'h0001, 1'b0, 1'b0, 1'b0); // R5 zero with carry

      // wide corners
      run_vec(16'h7FFF, 16'h0001, 1'b0, 1'b0, 1'b1);
      run_vec(16'h8000, 16'h0001, 1'b0, 1'b1, 1'b1);
      run_vec(16'hFFFF, 16'h0001, 1'b0, 1'b0, 1'b1);
      run_vec(16'h0100, 16'h0000, 1'b0, 1'b0, 1'b1); // R6 parity on low byte only
      run_vec(16'h0F0F, 16'h0101, 1'b0, 1'b0, 1'b1);

      // wide pseudo-random run
      lf = 16'hACE1;
      for (int n = 0; n < 6000; n++) begin
         logic [15:0] lb;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         lb = {lf[7:0], lf[15:8]} ^ 16'h3C5A;
         run_vec(lf, lb, lf[3], lf[9], 1'b1);
      end

      // R7: condition flags hold without arith_en
      run_vec(16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1);
      held = flags;
      op_a = 16'h8001; op_b = 16'h8001; op_sub = 1'b0; arith_en = 1'b0;
      @(negedge clk);
      check("R7", "hold without strobe", flags, held);

      // R8: control flags
      ctl_set = 3'b111;
      @(negedge clk);
      ctl_set = '0;
      check("R8", "set all", flags & 16'h0700, 16'h0700);
      @(negedge clk);
      check("R8", "hold set", flags & 16'h0700, 16'h0700);
      ctl_clr = 3'b010;
      @(negedge clk);
      ctl_clr = '0;
      check("R8", "clear interrupt", flags & 16'h0700, 16'h0500);
      ctl_set = 3'b011; ctl_clr = 3'b001;
      @(negedge clk);
      ctl_set = '0; ctl_clr = '0;
      check("R8", "clear wins", flags & 16'h0700, 16'h0600);
      run_vec(16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b1); // R7 arithmetic keeps ctl
      check("R7", "ctl after arith", flags & 16'h0700, 16'h0600);

      // R9: reset mid-run clears everything
      ctl_set = 3'b111;
      @(negedge clk);
      ctl_set = '0;
      rst_n = 1'b0;
      #1;
      check("R9", "async reset", flags, 16'h0002);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule